// File: doc/BRIEF.md
# Serial-controlled two-output AV source selector

This block is the digital control side of a two-output audio/video source selector. It is a standard-mode two-wire serial slave. A write transfer holds two control bytes, one for each output. The block decodes each byte into select codes for the composite video output and the audio pair. The first output also gets a luma/chroma select and an audio gain flag. A read transfer returns one status byte. That byte carries a sticky power-up flag and the four resolved states of two strap pins.

SCL and SDA reach the block already synchronized to `clk`. The block pulls SDA low through `sda_oe_o`, and the pad drives the line low whenever that signal is 1. The analog switches, the three-level voltage detection of the straps and the open-drain pad are outside the block.

The serial engine has eight states:
- `ST_IDLE`: waiting for a start condition.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: acknowledging a matching address.
- `ST_WR_BYTE`: shifting in a control byte.
- `ST_WR_ACK`: acknowledging a control byte.
- `ST_RD_BYTE`: shifting out the status byte.
- `ST_RD_ACK`: sampling the master's acknowledge.
- `ST_SKIP`: ignoring the bus until the next start.

The transitions are:
- A start condition in any state goes to `ST_ADDR`.
- A stop condition in any state goes to `ST_IDLE`.
- `ST_ADDR`, on the SCL fall after the eighth bit, goes to `ST_ADDR_ACK` on an address match and to `ST_SKIP` otherwise.
- `ST_ADDR_ACK`, on the next SCL fall, goes to `ST_RD_BYTE` for a read and to `ST_WR_BYTE` for a write.
- `ST_WR_BYTE`, after eight bits, goes to `ST_WR_ACK`.
- `ST_WR_ACK`, on the SCL fall, returns to `ST_WR_BYTE`.
- `ST_RD_BYTE`, after eight bits, goes to `ST_RD_ACK`.
- `ST_RD_ACK` goes to `ST_SKIP` when the master does not acknowledge. On an acknowledge it returns to `ST_RD_BYTE` on the SCL fall.

Top module: `avx_xpoint_ctrl`

## Requirements
- R1: The 7-bit device address is 1001_00s, where s is `addr_sel_i`. The eighth address bit is 0 for a write and 1 for a read. A matching address is acknowledged by holding SDA low during the ninth clock. A non-matching address is not acknowledged, and the bus is then ignored until the next start.
- R2: In a write, the first data byte goes to output 1's control register and the second to output 2's. Every data byte is acknowledged. The third and later data bytes are acknowledged and discarded.
- R3: After reset, both control registers are zero. Every select output then reads 0 (mute) and `aout1_gain_o` reads 0.
- R4: Control bits 6:3 form the video code, and bits 2:0 of that code pick the composite source. Source values are 0 mute, 1 MTV, 2 V1, 3 V2, 4 V3 and 5 STV, equal to the code bits. Codes 6 and 7 give 0. Bit 6 of the control byte does not change the source.
- R5: The mix flag of an output is 1 exactly when control bit 6 is 1 and bits 5:3 are 2 or 3. This is mixed Y+C from V1 or V2.
- R6: The `yc1_sel_o` encoding is 0 mute, 1 for the dedicated Y/C input pair, 2 for V1 and 3 for V2. It is 0 when output 1's composite source is 0. It is 2 or 3 when mix is set. It is 1 otherwise.
- R7: Control bits 2:0 pick the audio source with the mapping of R4: 0..5 unchanged, 6 and 7 give 0. Output 1 uses control register 1 and output 2 uses control register 2.
- R8: While `mute_i` is 1, both audio selects read 0 and the video selects are unchanged. Releasing `mute_i` restores the decoded audio codes.
- R9: `aout1_gain_o` equals bit 7 of control register 1, where 1 means 0 dB and 0 means -6 dB.
- R10: The status byte, sent MSB first, is {power-up flag, `strap_i[3:0]`, 3'b000}. `strap_i` is ordered {strap 1 open, strap 1 grounded, strap 2 open, strap 2 grounded}. If the master acknowledges, the byte is sent again with current values.
- R11: The power-up flag is 1 after reset and is returned as 1 by the first read. It clears when a read address is acknowledged and never sets again before reset.
- R12: A start or repeated start aborts the transfer in progress. A control register changes only after all eight bits of its byte have arrived, and a partial byte is discarded.
- R13: The slave drives SDA only in its acknowledge slots and in the status data bits. After a not-acknowledge from the master it releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| scl_i | input | 1 | Synchronized serial clock |
| sda_i | input | 1 | Synchronized serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| addr_sel_i | input | 1 | Address select strap, sets address bit s |
| mute_i | input | 1 | External audio mute |
| strap_i | input | 4 | Resolved strap states {s1 open, s1 gnd, s2 open, s2 gnd} |
| vout1_src_o | output | 3 | Output 1 composite source code |
| vout1_mix_o | output | 1 | Output 1 composite uses mixed Y+C |
| yc1_sel_o | output | 2 | Output 1 luma/chroma source |
| vout2_src_o | output | 3 | Output 2 composite source code |
| vout2_mix_o | output | 1 | Output 2 composite uses mixed Y+C |
| aout1_src_o | output | 3 | Output 1 audio source code |
| aout2_src_o | output | 3 | Output 2 audio source code |
| aout1_gain_o | output | 1 | Output 1 audio gain, 1 = 0 dB |

## Verification
Two things happen on the same clock edge. On the SCL fall that closes a matching read address, the status byte is latched into the shifter, and the power-up flag starts to clear. The first read after reset provokes this. That read must return the flag as 1, and a second read must return it as 0. A flag that cleared before the latch, or not at all, shows up in the byte compared at the ports.

// File: rtl/avx_pkg.sv
package avx_pkg;
    localparam int BYTE_W   = 8;
    localparam int NUM_CTRL = 2;
    localparam int SRC_W    = 3;
    localparam int STRAP_W  = 4;
    localparam int CNT_W    = $clog2(BYTE_W + 1);
    localparam int IDX_W    = $clog2(NUM_CTRL + 1);
    localparam int SRC_MAX  = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_SKIP
    } fsm_st_t;

    function automatic logic [SRC_W-1:0] map_src(input logic [2:0] code);
        return (int'(code) > SRC_MAX) ? '0 : code;
    endfunction

    function automatic logic mix_of(input logic [3:0] vcode);
        return vcode[3] && (vcode[2:1] == 2'b01);
    endfunction
endpackage

// File: rtl/avx_bus_edges.sv
module avx_bus_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise_o = scl_i & ~scl_q;
    assign scl_fall_o = ~scl_i & scl_q;
    assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/avx_i2c_fsm.sv
module avx_i2c_fsm
    import avx_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sda_i,
    input  logic                     scl_rise_i,
    input  logic                     scl_fall_i,
    input  logic                     start_i,
    input  logic                     stop_i,
    input  logic [6:0]               dev_addr_i,
    input  logic [BYTE_W-1:0]        status_i,
    output logic [NUM_CTRL-1:0]      wr_stb_o,
    output logic [BYTE_W-1:0]        wr_data_o,
    output logic                     rd_begin_o,
    output logic                     sda_oe_o,
    output fsm_st_t                  st_o
);
    fsm_st_t           state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              rw_q;
    logic [IDX_W-1:0]  idx;

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
    localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(NUM_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            rw_q       <= 1'b0;
            idx        <= '0;
            wr_stb_o   <= '0;
            wr_data_o  <= '0;
            rd_begin_o <= 1'b0;
        end else begin
            wr_stb_o   <= '0;
            rd_begin_o <= 1'b0;
            if (start_i) begin
                state <= ST_ADDR;
                cnt   <= '0;
            end else if (stop_i) begin
                state <= ST_IDLE;
            end else begin
                unique case (state)
                    ST_IDLE, ST_SKIP: begin
                    end
                    ST_ADDR: begin
                        if (scl_rise_i) begin
                            rx_sh <= {rx_sh[BYTE_W-2:0], sda_i};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall_i && cnt == LAST_BIT) begin
                            if (rx_sh[BYTE_W-1:1] == dev_addr_i) begin
                                state <= ST_ADDR_ACK;
                                rw_q  <= rx_sh[0];
                                if (rx_sh[0]) begin
                                    tx_sh      <= status_i;
                                    rd_begin_o <= 1'b1;
                                end
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall_i) begin
                            cnt   <= '0;
                            idx   <= '0;
                            state <= rw_q ? ST_RD_BYTE : ST_WR_BYTE;
                        end
                    end
                    ST_WR_BYTE: begin
                        if (scl_rise_i) begin
                            rx_sh <= {rx_sh[BYTE_W-2:0], sda_i};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall_i && cnt == LAST_BIT) begin
                            if (idx != IDX_END) begin
                                wr_stb_o[idx] <= 1'b1;
                                wr_data_o     <= rx_sh;
                                idx           <= idx + 1'b1;
                            end
                            state <= ST_WR_ACK;
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall_i) begin
                            cnt   <= '0;
                            state <= ST_WR_BYTE;
                        end
                    end
                    ST_RD_BYTE: begin
                        if (scl_rise_i) begin
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall_i) begin
                            if (cnt == LAST_BIT) state <= ST_RD_ACK;
                            else                 tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise_i && sda_i) begin
                            state <= ST_SKIP;
                        end else if (scl_fall_i) begin
                            cnt   <= '0;
                            tx_sh <= status_i;
                            state <= ST_RD_BYTE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        st_o     = state;
        sda_oe_o = 1'b0;
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe_o = 1'b1;
            ST_RD_BYTE:             sda_oe_o = ~tx_sh[BYTE_W-1];
            default:                sda_oe_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/avx_ctrl_regs.sv
module avx_ctrl_regs
    import avx_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_CTRL-1:0]              wr_stb_i,
    input  logic [BYTE_W-1:0]                wr_data_i,
    input  logic                             rd_begin_i,
    output logic [NUM_CTRL-1:0][BYTE_W-1:0]  ctrl_o,
    output logic                             pon_o
);
    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          ctrl_o[g] <= '0;
            else if (wr_stb_i[g]) ctrl_o[g] <= wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pon_o <= 1'b1;
        else if (rd_begin_i) pon_o <= 1'b0;
    end
endmodule

// File: rtl/avx_route_decode.sv
module avx_route_decode
    import avx_pkg::*;
(
    input  logic [NUM_CTRL-1:0][BYTE_W-1:0] ctrl_i,
    input  logic                            mute_i,
    output logic [NUM_CTRL-1:0][SRC_W-1:0]  vsrc_o,
    output logic [NUM_CTRL-1:0]             vmix_o,
    output logic [NUM_CTRL-1:0][SRC_W-1:0]  asrc_o,
    output logic [1:0]                      yc1_o,
    output logic                            gain1_o
);
    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_out
        always_comb begin
            vsrc_o[g] = map_src(ctrl_i[g][5:3]);
            vmix_o[g] = mix_of(ctrl_i[g][6:3]);
            asrc_o[g] = mute_i ? '0 : map_src(ctrl_i[g][2:0]);
        end
    end

    always_comb begin
        if (vsrc_o[0] == '0)  yc1_o = 2'd0;
        else if (vmix_o[0])   yc1_o = {1'b1, ctrl_i[0][3]};
        else                  yc1_o = 2'd1;
        gain1_o = ctrl_i[0][7];
    end
endmodule

// File: rtl/avx_xpoint_ctrl.sv
module avx_xpoint_ctrl
    import avx_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe_o,
    input  logic               addr_sel_i,
    input  logic               mute_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic [SRC_W-1:0]   vout1_src_o,
    output logic               vout1_mix_o,
    output logic [1:0]         yc1_sel_o,
    output logic [SRC_W-1:0]   vout2_src_o,
    output logic               vout2_mix_o,
    output logic [SRC_W-1:0]   aout1_src_o,
    output logic [SRC_W-1:0]   aout2_src_o,
    output logic               aout1_gain_o
);
    logic scl_rise_w, scl_fall_w, start_w, stop_w;
    logic [NUM_CTRL-1:0]              wr_stb_w;
    logic [BYTE_W-1:0]                wr_data_w;
    logic                             rd_begin_w;
    logic                             pon_w;
    fsm_st_t                          st_w;
    logic [NUM_CTRL-1:0][BYTE_W-1:0]  ctrl_w;
    logic [NUM_CTRL-1:0][SRC_W-1:0]   vsrc_w, asrc_w;
    logic [NUM_CTRL-1:0]              vmix_w;
    logic [6:0]                       dev_addr_w;
    logic [BYTE_W-1:0]                status_w;

    assign dev_addr_w = {DEV_ADDR[6:1], addr_sel_i};
    assign status_w   = {pon_w, strap_i, {(BYTE_W-1-STRAP_W){1'b0}}};

    avx_bus_edges u_edges (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise_o(scl_rise_w), .scl_fall_o(scl_fall_w),
        .start_o(start_w), .stop_o(stop_w)
    );

    avx_i2c_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_i(sda_i),
        .scl_rise_i(scl_rise_w), .scl_fall_i(scl_fall_w),
        .start_i(start_w), .stop_i(stop_w),
        .dev_addr_i(dev_addr_w), .status_i(status_w),
        .wr_stb_o(wr_stb_w), .wr_data_o(wr_data_w),
        .rd_begin_o(rd_begin_w), .sda_oe_o(sda_oe_o), .st_o(st_w)
    );

    avx_ctrl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_stb_i(wr_stb_w), .wr_data_i(wr_data_w),
        .rd_begin_i(rd_begin_w), .ctrl_o(ctrl_w), .pon_o(pon_w)
    );

    avx_route_decode u_dec (
        .ctrl_i(ctrl_w), .mute_i(mute_i), .vsrc_o(vsrc_w), .vmix_o(vmix_w),
        .asrc_o(asrc_w), .yc1_o(yc1_sel_o), .gain1_o(aout1_gain_o)
    );

    assign vout1_src_o = vsrc_w[0];
    assign vout2_src_o = vsrc_w[1];
    assign vout1_mix_o = vmix_w[0];
    assign vout2_mix_o = vmix_w[1];
    assign aout1_src_o = asrc_w[0];
    assign aout2_src_o = asrc_w[1];
endmodule

// File: rtl/avx_xpoint_ctrl_chk.sv
module avx_xpoint_ctrl_chk
    import avx_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 mute_i,
    input logic                 sda_oe_o,
    input logic [SRC_W-1:0]     vout1_src_o,
    input logic                 vout1_mix_o,
    input logic [1:0]           yc1_sel_o,
    input logic [SRC_W-1:0]     aout1_src_o,
    input logic [SRC_W-1:0]     aout2_src_o,
    input fsm_st_t              st,
    input logic [NUM_CTRL-1:0]  wr_stb,
    input logic [BYTE_W-1:0]    ctrl0,
    input logic                 pon,
    input logic                 rd_begin
);
    a_r8_mute_forces_audio: assert property (@(posedge clk) disable iff (!rst_n)
        mute_i |-> (aout1_src_o == '0 && aout2_src_o == '0));

    a_r6_mix_routes_yc: assert property (@(posedge clk) disable iff (!rst_n)
        vout1_mix_o |-> (vout1_src_o[2:1] == 2'b01 && yc1_sel_o == vout1_src_o[1:0]));

    a_r13_quiet_outside_slots: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE || st == ST_SKIP || st == ST_ADDR || st == ST_WR_BYTE || st == ST_RD_ACK)
        |-> !sda_oe_o);

    a_r12_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb[0] |=> $stable(ctrl0));

    a_r11_pon_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pon) |-> $past(rd_begin));

    a_r11_pon_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !pon |=> !pon);
endmodule

bind avx_xpoint_ctrl avx_xpoint_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mute_i(mute_i), .sda_oe_o(sda_oe_o),
    .vout1_src_o(vout1_src_o), .vout1_mix_o(vout1_mix_o), .yc1_sel_o(yc1_sel_o),
    .aout1_src_o(aout1_src_o), .aout2_src_o(aout2_src_o),
    .st(st_w), .wr_stb(wr_stb_w), .ctrl0(ctrl_w[0]), .pon(pon_w), .rd_begin(rd_begin_w)
);

// File: tb/avx_xpoint_ctrl_tb.sv
module avx_xpoint_ctrl_tb;
    localparam int Q = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_ln;
    logic addr_sel = 1'b0;
    logic mute = 1'b0;
    logic [3:0] strap = 4'b1010;
    logic [2:0] v1src, v2src, a1src, a2src;
    logic       v1mix, v2mix, gain1;
    logic [1:0] yc1;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;
    assign sda_ln = sda_m & ~sda_oe;

    avx_xpoint_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_ln), .sda_oe_o(sda_oe),
        .addr_sel_i(addr_sel), .mute_i(mute), .strap_i(strap),
        .vout1_src_o(v1src), .vout1_mix_o(v1mix), .yc1_sel_o(yc1),
        .vout2_src_o(v2src), .vout2_mix_o(v2mix),
        .aout1_src_o(a1src), .aout2_src_o(a2src), .aout1_gain_o(gain1)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
    endtask

    task automatic clk_bit(input logic b, output logic smp);
        sda_m = b; tick(Q); scl = 1'b1; tick(Q); smp = sda_ln; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic read_byte(input logic master_ack, output logic [7:0] d);
        logic s;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, s);
            d = {d[6:0], s};
        end
        clk_bit(~master_ack, s);
    endtask

    task automatic wr_frame(input logic [7:0] a, input logic [7:0] b1, input logic [7:0] b2,
                            output logic [2:0] acks);
        logic k;
        bus_start;
        send_byte(a, k);  acks[2] = k;
        send_byte(b1, k); acks[1] = k;
        send_byte(b2, k); acks[0] = k;
        bus_stop;
        tick(2);
    endtask

    function automatic int e_src(input int c3);
        return (c3 > 5) ? 0 : c3;
    endfunction
    function automatic int e_mix(input int c);
        return (((c >> 6) & 1) == 1 && (((c >> 3) & 7) == 2 || ((c >> 3) & 7) == 3)) ? 1 : 0;
    endfunction
    function automatic int e_yc(input int c);
        int s;
        s = e_src((c >> 3) & 7);
        if (s == 0) return 0;
        if (e_mix(c) == 1) return s;
        return 1;
    endfunction

    task automatic check_outputs(input int c1, input int c2, input logic m, input string tag);
        check({tag, " R4 vout1_src"}, v1src, e_src((c1 >> 3) & 7));
        check({tag, " R5 vout1_mix"}, v1mix, e_mix(c1));
        check({tag, " R6 yc1_sel"},   yc1,   e_yc(c1));
        check({tag, " R9 gain1"},     gain1, (c1 >> 7) & 1);
        check({tag, " R4 vout2_src"}, v2src, e_src((c2 >> 3) & 7));
        check({tag, " R5 vout2_mix"}, v2mix, e_mix(c2));
        check({tag, " R7 R8 aout1"},  a1src, m ? 0 : e_src(c1 & 7));
        check({tag, " R7 R8 aout2"},  a2src, m ? 0 : e_src(c2 & 7));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [2:0] acks;
        logic [7:0] d;
        logic k, s;
        tick(4);
        rst_n = 1'b1;
        tick(4);

        // R3: reset state
        check_outputs(0, 0, 1'b0, "reset R3");
        check("R13 idle sda released", sda_oe, 0);

        // R10 R11: first read returns power-up flag set
        bus_start;
        send_byte(8'h91, k); check("R1 read addr ack", k, 1);
        read_byte(1'b0, d);  check("R10 R11 first status", d, 8'hD0);
        check("R13 released after nack", sda_ln, 1);
        bus_stop;
        strap = 4'b0101;
        bus_start;
        send_byte(8'h91, k);
        read_byte(1'b1, d);  check("R11 flag cleared", d, 8'h28);
        read_byte(1'b0, d);  check("R10 repeated status byte", d, 8'h28);
        bus_stop;
        tick(2);

        // R2 R4 R5 R6 R7 R9: sweep all control values on output 1, complement on output 2
        for (int v = 0; v < 256; v++) begin
            wr_frame(8'h90, 8'(v), 8'(255 - v), acks);
            check("R1 R2 sweep acks", acks, 3'b111);
            check_outputs(v, 255 - v, 1'b0, "sweep");
        end

        // R2: fourth byte acknowledged and ignored
        bus_start;
        send_byte(8'h90, k);
        send_byte(8'h11, k);
        send_byte(8'h22, k);
        send_byte(8'h33, k); check("R2 extra byte ack", k, 1);
        send_byte(8'hFF, k); check("R2 second extra ack", k, 1);
        bus_stop;
        tick(2);
        check_outputs(8'h11, 8'h22, 1'b0, "extra R2");

        // R8: external mute
        mute = 1'b1; tick(2);
        check_outputs(8'h11, 8'h22, 1'b1, "mute R8");
        mute = 1'b0; tick(2);
        check_outputs(8'h11, 8'h22, 1'b0, "unmute R8");

        // R1: non-matching addresses ignored
        wr_frame(8'h94, 8'hFF, 8'hFF, acks);
        check("R1 wrong addr nack", acks, 3'b000);
        check_outputs(8'h11, 8'h22, 1'b0, "wrong addr R1");
        wr_frame(8'h92, 8'hFF, 8'hFF, acks);
        check("R1 other sel nack", acks[2], 0);
        check_outputs(8'h11, 8'h22, 1'b0, "other sel R1");

        // R1: address select high
        addr_sel = 1'b1; tick(2);
        wr_frame(8'h92, 8'h98, 8'h0D, acks);
        check("R1 sel1 acks", acks, 3'b111);
        check_outputs(8'h98, 8'h0D, 1'b0, "sel1 R1");
        wr_frame(8'h90, 8'h00, 8'h00, acks);
        check("R1 sel1 low addr nack", acks[2], 0);
        check_outputs(8'h98, 8'h0D, 1'b0, "sel1 low R1");
        bus_start;
        send_byte(8'h93, k); check("R1 sel1 read ack", k, 1);
        read_byte(1'b0, d);  check("R10 sel1 status", d, 8'h28);
        bus_stop;
        addr_sel = 1'b0; tick(2);

        // R12: partial second byte discarded
        bus_start;
        send_byte(8'h90, k);
        send_byte(8'h55, k);
        for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
        bus_start;
        bus_stop;
        tick(2);
        check_outputs(8'h55, 8'h0D, 1'b0, "partial R12");

        // R12: aborted address then full frame after repeated start
        bus_start;
        for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
        bus_start;
        send_byte(8'h90, k); check("R12 restart addr ack", k, 1);
        send_byte(8'h5D, k);
        send_byte(8'h06, k);
        bus_stop;
        tick(2);
        check_outputs(8'h5D, 8'h06, 1'b0, "restart R12");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule